// File: doc/BRIEF.md
# Line-Sensor Segment Scan Sequencer

This block is the digital sequencing logic that sits next to one segment of a linear photodiode array. It takes a block clock and an integrate pulse. It produces three kinds of output. The first is an integration-window flag, which lags both edges of the integrate pulse by a fixed number of clocks. The second is a one-hot channel select that steps through every element of the segment, one slot of four clocks per element. The third is a pair of strobes: a positive trigger in the middle of each slot, which downstream sampling logic uses, and an active-low end-of-scan pulse once the last slot is over.

A segment runs in one of two roles, chosen by a mode input. In master mode the falling edge of the integrate pulse starts a scan. The first channel appears after a fixed lead-in. In slave mode the block ignores that edge and instead waits for a falling edge on its start input. That input is wired to the end-of-scan output of the segment before it. The slave then begins channel 0 straight away, so several segments can take turns on one shared video line.

If a new integrate pulse begins while a scan is still running, the block raises a one-clock protocol-error flag. The running scan continues unchanged.

Top module: `scan_seq`

## Requirements
- R1: While rst_n is low and after it is released, integ_win, trig and proto_err are 0, eos_n is 1 and chan_sel is all zeros.
- R2: integ_win rises after the 8th rising clk edge, counting as edge 1 the edge at which integ_in is first sampled high. It falls after the 8th edge, counting as edge 1 the edge at which integ_in is first sampled low.
- R3: In master mode (slave_mode=0), call edge 1 the edge at which a high-to-low change of integ_in is sampled while idle. Channel i is then selected after edge 19+4i and stays selected for 4 clocks. Selection means bit i of chan_sel is the only bit set and chan_idx equals i.
- R4: trig is high for exactly one clock, in the third clock of each slot. For channel i in master mode that is after edge 21+4i.
- R5: After the 128th slot ends, eos_n is low for exactly one clock, after edge 531 in master mode. During that clock chan_sel is all zeros.
- R6: In slave mode, a high-to-low change of start_n sampled at edge S selects channel 0 right after edge S. A falling edge of integ_in does not start a scan in this mode.
- R7: In master mode, start_n has no effect. A low pulse on it while idle leaves chan_sel at zero.
- R8: A low-to-high change of integ_in sampled while a scan is in progress drives proto_err high for exactly the clock after that edge. The channel sequence and the end-of-scan timing are unchanged.
- R9: A start condition that arrives while a scan is in progress is ignored. The scan does not restart.
- R10: After end-of-scan the block stays idle, with chan_sel zero, until the next start condition. That start condition then runs a complete scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every count is in rising edges of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| integ_in | input | 1 | Integrate pulse; its falling edge starts a master scan |
| start_n | input | 1 | Active-low start from the preceding segment's eos_n (slave mode) |
| slave_mode | input | 1 | 0 = master, 1 = slave |
| integ_win | output | 1 | Delayed integration window |
| chan_sel | output | NCH | One-hot channel select, zero when no slot is active |
| chan_idx | output | $clog2(NCH) | Binary index of the selected channel |
| trig | output | 1 | Mid-slot sample strobe |
| eos_n | output | 1 | Active-low end-of-scan pulse |
| proto_err | output | 1 | One-clock flag: integrate pulse rose during a scan |

## Verification
The hardest case to reach is a new integrate rise, followed by its fall, in the middle of a running master scan. That stimulus produces both a protocol error and an ignored restart, and the only proof of correctness is that channel 127 and end-of-scan still land on the same edges as in an undisturbed scan. The bench counts edges from the start edge to the exact clock, toggles integ_in inside slot 20, and then checks the final slot and the end-of-scan pulse against the original schedule. The slave path is reached by switching the mode and pulsing start_n for one clock, the same pulse an upstream eos_n would give.

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int NCH       = 128,
  parameter int LEAD      = 19,
  parameter int SLOT      = 4,
  parameter int TRIG_PH   = 2,
  parameter int INTEG_DLY = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   integ_in,
  input  logic                   start_n,
  input  logic                   slave_mode,
  output logic                   integ_win,
  output logic [NCH-1:0]         chan_sel,
  output logic [$clog2(NCH)-1:0] chan_idx,
  output logic                   trig,
  output logic                   eos_n,
  output logic                   proto_err
);
  localparam int CW = $clog2(NCH);
  localparam int PW = (SLOT > 2) ? $clog2(SLOT) : 1;
  localparam int LW = $clog2(LEAD + 1);

  typedef enum logic [1:0] {IDLE, PRE, SCAN, DONE} st_t;

  st_t                  st;
  logic [LW-1:0]        lcnt;
  logic [PW-1:0]        ph;
  logic [CW-1:0]        ch;
  logic                 integ_q, start_q, err_q;
  logic [INTEG_DLY-1:0] dly;

  wire rise  = integ_in & ~integ_q;
  wire fall  = ~integ_in & integ_q;
  wire sfall = ~start_n & start_q;
  wire busy  = (st != IDLE);
  wire go_m  = ~slave_mode & fall;
  wire go_s  = slave_mode & sfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      lcnt    <= '0;
      ph      <= '0;
      ch      <= '0;
      integ_q <= 1'b0;
      start_q <= 1'b1;
      err_q   <= 1'b0;
      dly     <= '0;
    end else begin
      integ_q <= integ_in;
      start_q <= start_n;
      dly     <= {dly[INTEG_DLY-2:0], integ_in};
      err_q   <= rise & busy;
      case (st)
        IDLE: begin
          if (go_s) begin
            st <= SCAN;
            ch <= '0;
            ph <= '0;
          end else if (go_m) begin
            st   <= PRE;
            lcnt <= LW'(1);
          end
        end
        PRE: begin
          lcnt <= lcnt + LW'(1);
          if (lcnt == LW'(LEAD - 1)) begin
            st <= SCAN;
            ch <= '0;
            ph <= '0;
          end
        end
        SCAN: begin
          if (ph == PW'(SLOT - 1)) begin
            ph <= '0;
            if (ch == CW'(NCH - 1)) st <= DONE;
            else ch <= ch + CW'(1);
          end else begin
            ph <= ph + PW'(1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign integ_win = dly[INTEG_DLY-1];
  assign chan_sel  = (st == SCAN) ? ({{(NCH-1){1'b0}}, 1'b1} << ch) : '0;
  assign chan_idx  = ch;
  assign trig      = (st == SCAN) && (ph == PW'(TRIG_PH));
  assign eos_n     = (st != DONE);
  assign proto_err = err_q;

  assert_trig_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  assert_trig_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $onehot(chan_sel));
  assert_eos_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !eos_n |=> eos_n);
  assert_eos_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !eos_n |-> (chan_sel == '0));
  assert_first_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|chan_sel) |-> (chan_idx == '0));
  assert_err_keeps_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && $past(|chan_sel)) |-> ((|chan_sel) || !eos_n));
endmodule

// File: tb/test_scan_seq.sv
module test_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 128;

  logic clk = 1'b0, rst_n = 1'b0, integ_in = 1'b0, start_n = 1'b1, slave_mode = 1'b0;
  logic           integ_win, trig, eos_n, proto_err;
  logic [NCH-1:0] chan_sel;
  logic [6:0]     chan_idx;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  scan_seq i_scan_seq (
    .clk(clk), .rst_n(rst_n), .integ_in(integ_in), .start_n(start_n),
    .slave_mode(slave_mode), .integ_win(integ_win), .chan_sel(chan_sel),
    .chan_idx(chan_idx), .trig(trig), .eos_n(eos_n), .proto_err(proto_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // {offset after start edge[11:0], idx[7:0], trig, sel_on, eos_n, win}
  localparam logic [23:0] VEC [0:13] = '{
    {12'd6,   8'd0,   1'b0, 1'b0, 1'b1, 1'b1},
    {12'd7,   8'd0,   1'b0, 1'b0, 1'b1, 1'b0},
    {12'd17,  8'd0,   1'b0, 1'b0, 1'b1, 1'b0},
    {12'd18,  8'd0,   1'b0, 1'b1, 1'b1, 1'b0},
    {12'd20,  8'd0,   1'b1, 1'b1, 1'b1, 1'b0},
    {12'd21,  8'd0,   1'b0, 1'b1, 1'b1, 1'b0},
    {12'd22,  8'd1,   1'b0, 1'b1, 1'b1, 1'b0},
    {12'd24,  8'd1,   1'b1, 1'b1, 1'b1, 1'b0},
    {12'd274, 8'd64,  1'b0, 1'b1, 1'b1, 1'b0},
    {12'd276, 8'd64,  1'b1, 1'b1, 1'b1, 1'b0},
    {12'd526, 8'd127, 1'b0, 1'b1, 1'b1, 1'b0},
    {12'd528, 8'd127, 1'b1, 1'b1, 1'b1, 1'b0},
    {12'd530, 8'd0,   1'b0, 1'b0, 1'b0, 1'b0},
    {12'd531, 8'd0,   1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] onehot(input int i);
    return {{(NCH-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int cur;
    @(negedge clk);
    check("R1 sel in reset", 32'(chan_sel == '0), 1);
    check("R1 eos_n in reset", 32'(eos_n), 1);
    rst_n = 1'b1;
    step(2);
    check("R1 sel", 32'(chan_sel == '0), 1);
    check("R1 trig", 32'(trig), 0);
    check("R1 err", 32'(proto_err), 0);
    check("R1 win", 32'(integ_win), 0);

    // R2: window rise, then master scan walked through the vector table
    integ_in = 1'b1;
    step(1);
    step(6);
    check("R2 win before 8th edge", 32'(integ_win), 0);
    step(1);
    check("R2 win after 8th edge", 32'(integ_win), 1);
    step(30);
    integ_in = 1'b0;
    step(1);
    cur = 0;
    for (int k = 0; k < 14; k++) begin
      int off;
      string tag;
      off = int'(VEC[k][23:12]);
      step(off - cur);
      cur = off;
      tag = (off < 8) ? "R2" : (!VEC[k][1]) ? "R5" : VEC[k][3] ? "R4" : "R3";
      check({tag, " sel"}, 32'(chan_sel == (VEC[k][2] ? onehot(int'(VEC[k][11:4])) : '0)), 1);
      if (VEC[k][2]) check({tag, " idx"}, 32'(chan_idx), 32'(VEC[k][11:4]));
      check({tag, " trig"}, 32'(trig), 32'(VEC[k][3]));
      check({tag, " eos_n"}, 32'(eos_n), 32'(VEC[k][1]));
      check({tag, " win"}, 32'(integ_win), 32'(VEC[k][0]));
    end
    step(20);
    check("R10 idle after eos", 32'(chan_sel == '0), 1);

    // R8/R9: integrate pulse toggled mid-scan
    integ_in = 1'b1;
    step(10);
    integ_in = 1'b0;
    step(1);
    step(100);
    integ_in = 1'b1;
    step(1);
    check("R8 err raised", 32'(proto_err), 1);
    check("R8 scan intact idx", 32'(chan_idx), 20);
    step(1);
    check("R8 err one clock", 32'(proto_err), 0);
    integ_in = 1'b0;
    step(1);
    check("R9 no restart", 32'(chan_idx), 21);
    step(424);
    check("R8 last channel", 32'(chan_sel == onehot(127)), 1);
    step(3);
    check("R8 eos timing", 32'(eos_n), 0);
    step(1);
    check("R10 eos released", 32'(eos_n), 1);

    // R7: master ignores start_n
    start_n = 1'b0;
    step(1);
    start_n = 1'b1;
    step(25);
    check("R7 start_n ignored", 32'(chan_sel == '0), 1);

    // R6: slave mode
    slave_mode = 1'b1;
    integ_in = 1'b1;
    step(5);
    integ_in = 1'b0;
    step(25);
    check("R6 integ fall ignored", 32'(chan_sel == '0), 1);
    start_n = 1'b0;
    step(1);
    start_n = 1'b1;
    check("R6 ch0 at once", 32'(chan_sel == onehot(0)), 1);
    step(2);
    check("R6 trig slot 0", 32'(trig), 1);
    step(2);
    check("R6 ch1", 32'(chan_idx), 1);
    step(508);
    check("R6 eos slave", 32'(eos_n), 0);
    check("R6 sel zero at eos", 32'(chan_sel == '0), 1);
    finish_run();
  end
endmodule